// File: doc/BRIEF.md
# Converter Calibration Phase Sequencer

This block is the control state machine of a delta-sigma converter. It sequences calibration work that is measured in whole conversion periods. A 3-bit operating-mode field is written through a simple write strobe. On each conversion-period tick the sequencer decides whether to keep producing ordinary results or to begin a calibration sequence. The digital filter, the coefficient arithmetic and the host link are not part of the block. They appear only as the `conv_tick` input and as the control outputs that the sequencer drives.

Two sequences are supported. The one-shot system sequence calibrates offset on the live input, then calibrates gain with the sampler switched to the reference. It then clears the mode field and waits for the filter to refill. The background sequence shorts the sampler inputs for an offset pass, reconnects the input and lets the filter refill. It repeats this loop for as long as the mode field keeps asking for it. While any sequence runs, the active-low data-ready output is held high, so no result is flagged until the filter holds valid data again. A slave-mode input adds one period to the offset phase in the cases described below.

Top module: `cal_seq_ctrl`

## Requirements
- R1: After synchronous reset, the mode field reads 000, `in_sel` is 00 (analog input), both calibration enables are low, `drdy_n` is high, and `busy` and `done` are low.
- R2: In normal mode, and for every mode code other than 100 and 101, each `conv_tick` drives `drdy_n` low for exactly one clock cycle after the tick edge. A mode write changes the mode field at once but starts nothing until the next tick.
- R3: When a tick arrives with mode code 100, the offset phase starts: `ofs_en` is high, `in_sel` stays 00 (live analog input), and the phase lasts 3 ticks when `slave_mode` is low.
- R4: The gain phase of the code-100 sequence follows the offset phase. For 3 ticks it has `gain_en` high and `in_sel` at 10 (reference). At the tick that ends it, the mode field returns to 000.
- R5: After the last calibration phase of either sequence comes a refill phase. It lasts 3 ticks with `in_sel` at 00, both enables low and `drdy_n` high. Valid data is flagged at its third tick. A code-100 sequence therefore flags data on the 9th tick after acceptance when `slave_mode` is low.
- R6: When a tick arrives with mode code 101, the background loop starts. Its offset phase uses `in_sel` 01 (shorted inputs) with `ofs_en` high for 3 ticks, and a refill follows. Valid data is flagged every 6th tick, and the loop re-enters its offset phase on that same tick while the mode field stays 101.
- R7: With `slave_mode` high, the code-100 offset phase always lasts 4 ticks. The background offset phase lasts 4 ticks only the first time after reset, and 3 ticks on every later pass.
- R8: If the mode field is rewritten away from 101 during a background pass, that pass still completes. The controller then returns to normal mode and flags data on every tick.
- R9: `busy` rises at the accepting tick and falls when `drdy_n` first goes low afterwards. `done` pulses for one cycle together with each data-ready pulse that ends a sequence pass.
- R10: `drdy_n` stays high throughout every calibration and refill phase. The two enables are never high together, and `in_sel` never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 3 | New mode field value |
| slave_mode | input | 1 | Converter runs as a clock slave (longer offset phases) |
| conv_tick | input | 1 | One-cycle pulse at each conversion-period boundary |
| mode_q | output | 3 | Current mode field |
| in_sel | output | 2 | Sampler source: 00 analog, 01 shorted, 10 reference |
| ofs_en | output | 1 | Offset calibration enable |
| gain_en | output | 1 | Gain calibration enable |
| drdy_n | output | 1 | Data ready, active low |
| busy | output | 1 | Sequence accepted and no valid data yet |
| done | output | 1 | One-cycle pulse at the end of each sequence pass |

## Verification
The assertions assume that `conv_tick` is a single-cycle pulse. They also assume that ticks are spaced by more than one clock, so every data-ready pulse has returned high before the next boundary. The stimulus drives each tick for one cycle and then leaves at least one idle cycle. Mode writes are applied only between ticks, never in the same cycle as a tick, so the bench's expected phase positions stay well defined.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    localparam logic [2:0] MODE_NORMAL = 3'b000;
    localparam logic [2:0] MODE_SYSCAL = 3'b100;
    localparam logic [2:0] MODE_BGCAL  = 3'b101;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_OFFSET = 2'd1,
        PH_GAIN   = 2'd2,
        PH_REFILL = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SEL_ANALOG = 2'b00,
        SEL_SHORT  = 2'b01,
        SEL_REF    = 2'b10
    } insel_e;

    typedef struct packed {
        phase_e phase;
        logic   bg;     // running sequence is the background loop
    } seq_state_t;

    typedef struct packed {
        logic accept;    // calibration command taken at this tick
        logic valid;     // a conversion result is flagged at this tick
        logic pass_end;  // a sequence pass finished at this tick
        logic mode_clr;  // mode field returns to normal
        logic phase_chg; // phase boundary, restart the period counter
    } seq_evt_t;

    function automatic logic is_cal_cmd(input logic [2:0] m);
        return (m == MODE_SYSCAL) || (m == MODE_BGCAL);
    endfunction

    function automatic insel_e sel_for(input seq_state_t s);
        case (s.phase)
            PH_OFFSET: return s.bg ? SEL_SHORT : SEL_ANALOG;
            PH_GAIN:   return SEL_REF;
            default:   return SEL_ANALOG;
        endcase
    endfunction

endpackage

// File: rtl/cal_mode_reg.sv
module cal_mode_reg #(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    input  logic              clr,
    output logic [MODE_W-1:0] mode_q
);
    logic [MODE_W-1:0] mode_r;

    // A host write in the same cycle as the self-clear wins.
    always_ff @(posedge clk) begin
        if (rst)
            mode_r <= '0;
        else if (wr)
            mode_r <= wdata;
        else if (clr)
            mode_r <= '0;
    end

    assign mode_q = mode_r;
endmodule

// File: rtl/cal_phase_timer.sv
module cal_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_r;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_r <= '0;
        else if (tick)
            cnt_r <= cnt_r + CNT_W'(1);
    end

    // The tick that completes the programmed number of periods
    assign last = tick && (cnt_r == limit - CNT_W'(1));
endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
    import cal_seq_pkg::*;
#(
    parameter int CAL_PERIODS    = 3,
    parameter int REFILL_PERIODS = 3,
    parameter int SLAVE_EXTRA    = 1,
    parameter int CNT_W          = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             slave,
    input  logic [2:0]       mode,
    input  logic             timer_last,
    output seq_state_t       st,
    output logic             timer_clr,
    output logic [CNT_W-1:0] limit,
    output seq_evt_t         evt
);
    seq_state_t       st_q, st_d;
    logic             first_q, first_d;
    logic             extra_on;
    logic [CNT_W-1:0] ofs_len;

    // Code-100 offset always pays the slave penalty; background only once.
    assign extra_on = slave && (!st_q.bg || !first_q);
    assign ofs_len  = CNT_W'(CAL_PERIODS) + (extra_on ? CNT_W'(SLAVE_EXTRA) : '0);

    always_comb begin
        case (st_q.phase)
            PH_OFFSET: limit = ofs_len;
            PH_GAIN:   limit = CNT_W'(CAL_PERIODS);
            PH_REFILL: limit = CNT_W'(REFILL_PERIODS);
            default:   limit = CNT_W'(CAL_PERIODS);
        endcase
    end

    always_comb begin
        st_d    = st_q;
        first_d = first_q;
        evt     = '0;
        case (st_q.phase)
            PH_IDLE: begin
                if (tick) begin
                    if (is_cal_cmd(mode)) begin
                        st_d.phase    = PH_OFFSET;
                        st_d.bg       = (mode == MODE_BGCAL);
                        evt.accept    = 1'b1;
                        evt.phase_chg = 1'b1;
                    end else begin
                        evt.valid = 1'b1;
                    end
                end
            end
            PH_OFFSET: begin
                if (timer_last) begin
                    first_d       = 1'b1;
                    st_d.phase    = st_q.bg ? PH_REFILL : PH_GAIN;
                    evt.phase_chg = 1'b1;
                end
            end
            PH_GAIN: begin
                if (timer_last) begin
                    st_d.phase    = PH_REFILL;
                    evt.mode_clr  = 1'b1;
                    evt.phase_chg = 1'b1;
                end
            end
            PH_REFILL: begin
                if (timer_last) begin
                    evt.valid     = 1'b1;
                    evt.pass_end  = 1'b1;
                    evt.phase_chg = 1'b1;
                    if (st_q.bg && (mode == MODE_BGCAL)) begin
                        st_d.phase = PH_OFFSET;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.bg    = 1'b0;
                    end
                end
            end
            default: st_d = '{phase: PH_IDLE, bg: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '{phase: PH_IDLE, bg: 1'b0};
            first_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            first_q <= first_d;
        end
    end

    assign st        = st_q;
    assign timer_clr = evt.phase_chg;
endmodule

// File: rtl/cal_out_drv.sv
module cal_out_drv
    import cal_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_t st,
    input  seq_evt_t   evt,
    output logic [1:0] in_sel,
    output logic       ofs_en,
    output logic       gain_en,
    output logic       drdy_n,
    output logic       busy,
    output logic       done
);
    logic drdy_n_r, busy_r, done_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            drdy_n_r <= 1'b1;
            busy_r   <= 1'b0;
            done_r   <= 1'b0;
        end else begin
            drdy_n_r <= !evt.valid;
            done_r   <= evt.pass_end;
            if (evt.accept)
                busy_r <= 1'b1;
            else if (evt.valid)
                busy_r <= 1'b0;
        end
    end

    assign in_sel  = sel_for(st);
    assign ofs_en  = (st.phase == PH_OFFSET);
    assign gain_en = (st.phase == PH_GAIN);
    assign drdy_n  = drdy_n_r;
    assign busy    = busy_r;
    assign done    = done_r;
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
    import cal_seq_pkg::*;
#(
    parameter int CAL_PERIODS    = 3,
    parameter int REFILL_PERIODS = 3,
    parameter int SLAVE_EXTRA    = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic [2:0] mode_wdata,
    input  logic       slave_mode,
    input  logic       conv_tick,
    output logic [2:0] mode_q,
    output logic [1:0] in_sel,
    output logic       ofs_en,
    output logic       gain_en,
    output logic       drdy_n,
    output logic       busy,
    output logic       done
);
    localparam int OFS_MAX = CAL_PERIODS + SLAVE_EXTRA;
    localparam int MAX_LEN = (OFS_MAX > REFILL_PERIODS) ? OFS_MAX : REFILL_PERIODS;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    seq_state_t       st;
    seq_evt_t         evt;
    logic             timer_clr, timer_last;
    logic [CNT_W-1:0] limit;

    cal_mode_reg #(.MODE_W(3)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr     (mode_wr),
        .wdata  (mode_wdata),
        .clr    (evt.mode_clr),
        .mode_q (mode_q)
    );

    cal_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (timer_clr),
        .tick  (conv_tick),
        .limit (limit),
        .last  (timer_last)
    );

    cal_seq_fsm #(
        .CAL_PERIODS    (CAL_PERIODS),
        .REFILL_PERIODS (REFILL_PERIODS),
        .SLAVE_EXTRA    (SLAVE_EXTRA),
        .CNT_W          (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (conv_tick),
        .slave      (slave_mode),
        .mode       (mode_q),
        .timer_last (timer_last),
        .st         (st),
        .timer_clr  (timer_clr),
        .limit      (limit),
        .evt        (evt)
    );

    cal_out_drv u_out (
        .clk     (clk),
        .rst     (rst),
        .st      (st),
        .evt     (evt),
        .in_sel  (in_sel),
        .ofs_en  (ofs_en),
        .gain_en (gain_en),
        .drdy_n  (drdy_n),
        .busy    (busy),
        .done    (done)
    );
endmodule

// File: rtl/cal_seq_ctrl_chk.sv
module cal_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       conv_tick,
    input logic [2:0] mode_q,
    input logic [1:0] in_sel,
    input logic       ofs_en,
    input logic       gain_en,
    input logic       drdy_n,
    input logic       busy,
    input logic       done
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == 3'b000 && in_sel == 2'b00 && !ofs_en && !gain_en
                        && drdy_n && !busy && !done));

    assert_drdy_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        !drdy_n |=> drdy_n);

    assert_drdy_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(drdy_n) |-> $past(conv_tick));

    assert_sel_moves_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(in_sel) |-> $past(conv_tick));

    assert_gain_uses_ref_R4: assert property (@(posedge clk) disable iff (rst)
        gain_en |-> in_sel == 2'b10);

    assert_done_with_drdy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !drdy_n);

    assert_busy_clears_on_data_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !drdy_n);

    assert_no_gain_when_valid_R10: assert property (@(posedge clk) disable iff (rst)
        !drdy_n |-> !gain_en);

    assert_enables_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(ofs_en && gain_en));

    assert_sel_legal_R10: assert property (@(posedge clk) disable iff (rst)
        in_sel != 2'b11);
endmodule

bind cal_seq_ctrl cal_seq_ctrl_chk u_chk (.*);

// File: tb/cal_seq_ctrl_tb.sv
`timescale 1ns/1ps
module cal_seq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_wdata = 3'b000;
    logic       slave_mode = 1'b0;
    logic       conv_tick = 1'b0;
    logic [2:0] mode_q;
    logic [1:0] in_sel;
    logic       ofs_en, gain_en, drdy_n, busy, done;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cal_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .slave_mode(slave_mode), .conv_tick(conv_tick), .mode_q(mode_q),
        .in_sel(in_sel), .ofs_en(ofs_en), .gain_en(gain_en), .drdy_n(drdy_n),
        .busy(busy), .done(done)
    );

    function automatic logic [9:0] pk(input logic [2:0] m, input logic [1:0] s,
                                      input logic o, input logic g, input logic dn,
                                      input logic b, input logic d);
        return {m, s, o, g, dn, b, d};
    endfunction

    function automatic logic [9:0] obs();
        return pk(mode_q, in_sel, ofs_en, gain_en, drdy_n, busy, done);
    endfunction

    task automatic chk(input string rq, input logic [9:0] act, input logic [9:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b (mode,sel,ofs,gain,drdy_n,busy,done)", rq, act, exp);
        end
    endtask

    task automatic write_mode(input logic [2:0] v);
        @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    // one conversion boundary; outputs sampled on the falling edge after it
    task automatic tick();
        @(negedge clk); conv_tick = 1'b1;
        @(negedge clk); conv_tick = 1'b0;
    endtask

    task automatic idle_check_high(input string rq);
        @(negedge clk);
        chk(rq, {9'd0, drdy_n}, 10'd1);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // One pass after its accepting tick. bg: background loop; olen: offset ticks;
    // first: busy held; cont: loop restarts; mval: mode written; stop_k: k after
    // which the mode field was rewritten to 000 (0 = never)
    task automatic run_pass(input bit bg, input int olen, input bit first, input bit cont,
                            input logic [2:0] mval, input int stop_k, input bit slv);
        int gain_n = bg ? 0 : 3;
        int total  = olen + gain_n + 3;
        for (int k = 1; k <= total; k++) begin
            logic [2:0] m;
            tick();
            m = (stop_k != 0 && k > stop_k) ? 3'b000 : mval;
            if (k < olen) begin
                chk(slv ? "R7 offset" : (bg ? "R6 offset" : "R3 offset"), obs(),
                    pk(m, bg ? 2'b01 : 2'b00, 1'b1, 1'b0, 1'b1, first, 1'b0));
            end else if (k < olen + gain_n) begin
                chk("R4 gain", obs(), pk(m, 2'b10, 1'b0, 1'b1, 1'b1, first, 1'b0));
            end else if (k < total) begin
                chk("R5 refill", obs(), pk(bg ? m : 3'b000, 2'b00, 1'b0, 1'b0, 1'b1, first, 1'b0));
            end else begin
                chk(cont ? "R6 restart" : "R9 pass end", obs(),
                    pk(bg ? m : 3'b000, cont ? 2'b01 : 2'b00, cont, 1'b0, 1'b0, 1'b0, 1'b1));
                idle_check_high("R2 drdy one cycle");
            end
            if (stop_k != 0 && k == stop_k) write_mode(3'b000);
        end
    endtask

    task automatic accept(input logic [2:0] cmd, input int slv);
        write_mode(cmd);
        chk("R2 write waits for tick", obs(), pk(cmd, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        tick();
        chk(slv != 0 ? "R7 accept" : (cmd == 3'b101 ? "R6 accept" : "R3 accept"), obs(),
            pk(cmd, cmd == 3'b101 ? 2'b01 : 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));
    endtask

    initial begin
        for (int s = 0; s < 2; s++) begin
            slave_mode = s[0];
            do_reset();
            chk("R1 reset", obs(), pk(3'b000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
            for (int i = 0; i < 2; i++) begin
                tick();
                chk("R2 normal", obs(), pk(3'b000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
                idle_check_high("R2 normal release");
            end
            for (int c = 1; c < 8; c++) begin
                if (c == 4 || c == 5) continue;
                write_mode(3'(c));
                tick();
                chk("R2 reserved code", obs(), pk(3'(c), 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
            end
            // background loop: first pass may be longer in slave mode
            accept(3'b101, s);
            run_pass(1'b1, 3 + s, 1'b1, 1'b1, 3'b101, 0, s != 0);
            run_pass(1'b1, 3, 1'b0, 1'b1, 3'b101, 0, 1'b0);
            run_pass(1'b1, 3, 1'b0, 1'b0, 3'b101, 2, 1'b0);
            tick();
            chk("R8 back to normal", obs(), pk(3'b000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
            // one-shot system sequence, twice: slave penalty applies each time
            for (int r = 0; r < 2; r++) begin
                accept(3'b100, s);
                run_pass(1'b0, 3 + s, 1'b1, 1'b0, 3'b100, 0, s != 0);
                tick();
                chk("R5 normal after", obs(), pk(3'b000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
            end
        end
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule